// File: doc/BRIEF.md
# Pipelined Bilinear Pixel Interpolator with Shared Vertical Term

The block produces the pixels of a rescaled image from a stream of source columns. Each accepted beat carries a pair of vertically adjacent source pixels (upper and lower) from one column, a vertical weight that stays fixed for a whole output row, and a horizontal weight that changes with every output pixel. For each new column the block first blends upper and lower along the vertical axis. It then blends horizontally between that column's vertical result and the one from the column before.

The vertical result of the earlier column is kept in a single register and is not recomputed. The arithmetic therefore needs only two multipliers, two subtracters and two adders. The datapath is a four-stage pipeline, and each multiplier spans two of those stages. A small control state machine decides when the column registers shift. It also decides which beats produce an output, and it tracks whether two columns of the current row have been loaded yet.

When the horizontal step is finer than one source pixel, the caller sends beats with the advance flag low. These beats reuse the same column pair and change only the horizontal weight.

Top module: `bilerp_scaler`

## Requirements
- R1: `outValid` is high in cycle t+4 exactly when a beat in cycle t produced an output. A beat produces an output when `inValid` and `inEmit` are both 1 and, after that beat, two columns of the current row are held. At all other times `outValid` is 0.
- R2: A beat with `inAdvance`=1 loads a vertical result V = U + floor(((L−U)·dy + 128) / 256). Here U is `inTop`, L is `inBot` and dy is `inDy`, an unsigned weight in units of 1/256. When `inDx`=0 the output equals the previous column's V exactly.
- R3: An output pixel equals A + floor(((B−A)·dx + 128) / 256). B is the most recently loaded column's V, A is the V of the column loaded before it, and dx is `inDx` in units of 1/256.
- R4: A beat with `inAdvance`=0 keeps both held column values unchanged, and its `inTop`, `inBot` and `inDy` have no effect. Its output uses the same column pair with the new `inDx`.
- R5: A beat with `inAdvance`=1 and `inRowStart`=1 makes its column the first of a new row. It produces no output even when `inEmit`=1, and the next advancing beat completes a pair.
- R6: After reset no column is held, so no output is produced until two columns have been loaded.
- R7: While `outValid` is 0, `outPix` keeps its last value. Reset drives `outValid` and `outPix` to 0.
- R8: When `inValid` is 0, every other input is ignored, and neither the held columns nor the outputs are affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Beat present this cycle |
| inAdvance | input | 1 | Beat brings a new source column |
| inRowStart | input | 1 | With inAdvance, column is the first of a row |
| inEmit | input | 1 | Beat requests an output pixel |
| inTop | input | PIX_W | Upper source pixel of the column |
| inBot | input | PIX_W | Lower source pixel of the column |
| inDy | input | FRAC_W | Vertical weight, units of 1/256 |
| inDx | input | FRAC_W | Horizontal weight, units of 1/256 |
| outValid | output | 1 | Output pixel valid |
| outPix | output | PIX_W | Interpolated output pixel |

## Verification
The bench drives runs of non-advancing beats with random pixel data. A design that refreshed the held pair on those beats would output values taken from the junk data. Emit requests are placed right after reset and right after a row start. A design that did not track priming would output a pixel blended against a stale column. Extreme weights and falling edges (upper 255, lower 0, weights 255) push the products negative, which exposes rounding written as truncation toward zero or as a logical shift. Zero horizontal weight exposes a swapped left and right operand.

// File: rtl/bilerp_pkg.sv
package bilerp_pkg;

  // Strobes from control to datapath, each aligned to the stage that uses it
  typedef struct packed {
    logic shiftCol;  // stage 2: load new vertical result, move old one left
    logic outLoad;   // stage 4: capture output pixel
  } lerpStrobe_t;

  typedef enum logic [1:0] {
    COL_NONE = 2'd0,
    COL_ONE  = 2'd1,
    COL_PAIR = 2'd2
  } colState_t;

endpackage

// File: rtl/bilerp_ctrl.sv
module bilerp_ctrl
  import bilerp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        inAdvance,
  input  logic        inRowStart,
  input  logic        inEmit,
  output lerpStrobe_t strobe,
  output logic        outValid
);

  localparam int FIRE_DLY = 3;

  colState_t state, nextState;
  logic loadCol;
  logic fire0;
  logic shiftS1;
  logic [FIRE_DLY-1:0] firePipe;

  assign loadCol = inValid && inAdvance;

  always_comb begin
    nextState = state;
    if (loadCol) begin
      if (inRowStart) begin
        nextState = COL_ONE;
      end else begin
        case (state)
          COL_NONE: nextState = COL_ONE;
          default:  nextState = COL_PAIR;
        endcase
      end
    end
  end

  assign fire0 = inValid && inEmit && (nextState == COL_PAIR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= COL_NONE;
      shiftS1  <= 1'b0;
      firePipe <= '0;
      outValid <= 1'b0;
    end else begin
      state    <= nextState;
      shiftS1  <= loadCol;
      firePipe <= {firePipe[FIRE_DLY-2:0], fire0};
      outValid <= firePipe[FIRE_DLY-1];
    end
  end

  assign strobe.shiftCol = shiftS1;
  assign strobe.outLoad  = firePipe[FIRE_DLY-1];

endmodule

// File: rtl/bilerp_datapath.sv
module bilerp_datapath
  import bilerp_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  lerpStrobe_t       strobe,
  input  logic [PIX_W-1:0]  inTop,
  input  logic [PIX_W-1:0]  inBot,
  input  logic [FRAC_W-1:0] inDy,
  input  logic [FRAC_W-1:0] inDx,
  output logic [PIX_W-1:0]  outPix
);

  localparam int DIFF_W = PIX_W + 1;
  localparam int PROD_W = DIFF_W + FRAC_W + 1;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC_W - 1);

  // base + round(prod / 2^FRAC_W); true result lies within pixel range
  function automatic logic [PIX_W-1:0] addScaled(
    input logic [PIX_W-1:0] base,
    input logic signed [PROD_W-1:0] prod
  );
    logic signed [PROD_W-1:0] sh;
    sh = (prod + HALF) >>> FRAC_W;
    return base + sh[PIX_W-1:0];
  endfunction

  // Stage 1: vertical difference and first multiplier stage
  logic signed [DIFF_W-1:0] vDiff;
  logic signed [FRAC_W:0]   dyS;
  logic signed [PROD_W-1:0] prodV;
  logic [PIX_W-1:0]         topS1;
  logic [FRAC_W-1:0]        dxS1;

  assign vDiff = $signed({1'b0, inBot}) - $signed({1'b0, inTop});
  assign dyS   = $signed({1'b0, inDy});

  // Stage 2: vertical result and the shared left-column register
  logic [PIX_W-1:0]  curV, leftV;
  logic [FRAC_W-1:0] dxS2;

  // Stage 3: horizontal difference and product
  logic signed [DIFF_W-1:0] hDiff;
  logic signed [FRAC_W:0]   dxS;
  logic signed [PROD_W-1:0] prodH;
  logic [PIX_W-1:0]         leftS3;

  assign hDiff = $signed({1'b0, curV}) - $signed({1'b0, leftV});
  assign dxS   = $signed({1'b0, dxS2});

  always_ff @(posedge clk) begin
    if (rst) begin
      prodV  <= '0;
      topS1  <= '0;
      dxS1   <= '0;
      curV   <= '0;
      leftV  <= '0;
      dxS2   <= '0;
      prodH  <= '0;
      leftS3 <= '0;
      outPix <= '0;
    end else begin
      prodV <= vDiff * dyS;
      topS1 <= inTop;
      dxS1  <= inDx;

      if (strobe.shiftCol) begin
        curV  <= addScaled(topS1, prodV);
        leftV <= curV;
      end
      dxS2 <= dxS1;

      prodH  <= hDiff * dxS;
      leftS3 <= leftV;

      if (strobe.outLoad) begin
        outPix <= addScaled(leftS3, prodH);
      end
    end
  end

endmodule

// File: rtl/bilerp_scaler.sv
module bilerp_scaler
  import bilerp_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inAdvance,
  input  logic              inRowStart,
  input  logic              inEmit,
  input  logic [PIX_W-1:0]  inTop,
  input  logic [PIX_W-1:0]  inBot,
  input  logic [FRAC_W-1:0] inDy,
  input  logic [FRAC_W-1:0] inDx,
  output logic              outValid,
  output logic [PIX_W-1:0]  outPix
);

  lerpStrobe_t strobe;

  bilerp_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .inAdvance  (inAdvance),
    .inRowStart (inRowStart),
    .inEmit     (inEmit),
    .strobe     (strobe),
    .outValid   (outValid)
  );

  bilerp_datapath #(
    .PIX_W  (PIX_W),
    .FRAC_W (FRAC_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .inTop  (inTop),
    .inBot  (inBot),
    .inDy   (inDy),
    .inDx   (inDx),
    .outPix (outPix)
  );

endmodule

// File: rtl/bilerp_checker.sv
module bilerp_checker #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inAdvance,
  input logic             inRowStart,
  input logic             inEmit,
  input logic             outValid,
  input logic [PIX_W-1:0] outPix
);

  // R1: an output can only come from an emit beat four cycles earlier
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid && inEmit, 4));

  // R5: a row-start column never yields an output
  p_row_start_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (inValid && inAdvance && inRowStart) |-> ##4 !outValid);

  // R8: an idle cycle never yields an output
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !inValid |-> ##4 !outValid);

  // R7: output pixel holds while not valid
  p_hold_out_r7: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outPix));

  // R7: reset clears the outputs
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (!outValid && outPix == '0));

endmodule

bind bilerp_scaler bilerp_checker #(.PIX_W(PIX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .inAdvance  (inAdvance),
  .inRowStart (inRowStart),
  .inEmit     (inEmit),
  .outValid   (outValid),
  .outPix     (outPix)
);

// File: tb/bilerp_scaler_test.sv
module bilerp_scaler_test;

  localparam int CLK_PERIOD = 10;
  localparam int PIX_W  = 8;
  localparam int FRAC_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, inAdvance = 1'b0, inRowStart = 1'b0, inEmit = 1'b0;
  logic [PIX_W-1:0]  inTop = '0, inBot = '0;
  logic [FRAC_W-1:0] inDy = '0, inDx = '0;
  logic outValid;
  logic [PIX_W-1:0] outPix;

  always #(CLK_PERIOD/2) clk = ~clk;

  bilerp_scaler #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inAdvance(inAdvance),
    .inRowStart(inRowStart), .inEmit(inEmit), .inTop(inTop), .inBot(inBot),
    .inDy(inDy), .inDx(inDx), .outValid(outValid), .outPix(outPix)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit    expV [8];
  int    expP [8];
  string expT [8];
  int lastPix = 0;
  int mCur = 0, mLeft = 0, mSt = 0;

  function automatic int lerp(int a, int b, int w);
    int p;
    p = (b - a) * w + 128;
    return a + (p >>> 8);
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic beat(bit v, bit adv, bit rs, bit em, int top, int bot, int dy, int dx);
    int s, s4;
    bit fire;
    @(negedge clk);
    s = cyc % 8;
    check(expT[s], int'(outValid), int'(expV[s]), "outValid");
    if (expV[s]) begin
      check(expT[s], int'(outPix), expP[s], "outPix");
      lastPix = expP[s];
    end else begin
      check("R7", int'(outPix), lastPix, "held outPix");
    end
    expV[s] = 1'b0;
    expT[s] = "R1";

    inValid = v; inAdvance = adv; inRowStart = rs; inEmit = em;
    inTop = PIX_W'(top); inBot = PIX_W'(bot);
    inDy = FRAC_W'(dy); inDx = FRAC_W'(dx);

    fire = 1'b0;
    s4 = (cyc + 4) % 8;
    if (v && adv) begin
      mLeft = mCur;
      mCur  = lerp(top, bot, dy);
      mSt   = rs ? 1 : ((mSt == 2) ? 2 : mSt + 1);
    end
    if (v && em && mSt == 2) fire = 1'b1;
    if (fire) begin
      expV[s4] = 1'b1;
      expP[s4] = lerp(mLeft, mCur, dx);
      expT[s4] = (dx == 0) ? "R2" : (!adv ? "R4" : "R3");
    end else if (em) begin
      expT[s4] = !v ? "R8" : (rs ? "R5" : "R6");
    end
    cyc++;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    for (int i = 0; i < 8; i++) begin expV[i] = 1'b0; expT[i] = "R1"; end
    seed = 32'h5eed1234;
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7", int'(outValid), 0, "reset outValid");
    check("R7", int'(outPix), 0, "reset outPix");

    // R6: emit before any column, then with only one column
    beat(1, 0, 0, 1, 99, 7, 30, 40);
    beat(1, 1, 0, 1, 10, 200, 128, 60);
    // R2: second column, dx = 0 gives previous column's vertical value (105)
    beat(1, 1, 0, 1, 50, 60, 10, 0);
    // R4: finer steps, junk pixels must not disturb the pair
    beat(1, 0, 0, 1, 255, 0, 255, 64);
    beat(1, 0, 0, 1, 3, 250, 1, 128);
    beat(1, 0, 0, 1, 0, 0, 0, 255);
    // R8: idle beat with every other flag set
    beat(0, 1, 1, 1, 17, 33, 200, 90);
    beat(1, 0, 0, 1, 1, 2, 3, 200);
    // R5: new row, column alone cannot emit
    beat(1, 1, 1, 1, 255, 0, 255, 255);
    beat(1, 0, 0, 1, 9, 9, 9, 100);
    // R3: falling edges with extreme weights
    beat(1, 1, 0, 1, 0, 255, 255, 255);
    beat(1, 1, 0, 1, 255, 0, 255, 255);
    beat(1, 1, 0, 1, 200, 0, 1, 1);

    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      beat(r < 85, ($urandom % 2) == 0, ($urandom % 10) == 0, ($urandom % 10) < 7,
           int'($urandom % 256), int'($urandom % 256),
           (($urandom % 8) == 0) ? 255 : int'($urandom % 256),
           (($urandom % 8) == 0) ? 0 : int'($urandom % 256));
    end
    for (int n = 0; n < 6; n++) beat(0, 0, 0, 0, 0, 0, 0, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule